// File: doc/BRIEF.md
# Capture Trigger Edge Selector

This block decides the clock cycles in which a timer channel samples a free-running counter into its capture holding register. A trigger can come from an external capture pin or from software. The pin is brought into the clock domain through a synchroniser chain and then watched for edges. Software triggers by rewriting a 2-bit source field between its "software low" and "software high" codes. A 2-bit edge-select field picks which edge direction counts: rising, falling or both. The same edge-select setting applies to the pin and to the software field.

On each accepted trigger the block raises a one-cycle capture strobe. In that same clock it loads the counter value into the holding register. A simple overrun flag records a capture that lands while the previous value is still unread. Software acknowledges a read with a one-cycle pulse. The flag stays set until software clears it.

Top module: `capture_edge_sel`

## Requirements
- R1: After reset, `cap_strobe`, `cap_value` and `ovf_flag` are all 0. The previous-source register resets to code 0, so a first write of 2 or 3 to `src_sel` after reset never captures.
- R2: With `edge_sel` = 1 (rising) and `src_sel` = 0 (pin), a 0-to-1 change of `cap_pin` set up before clock edge N gives `cap_strobe` high in the cycle after edge N+2. This is three cycles of latency: two synchroniser flops and one strobe register.
- R3: With `edge_sel` = 2 (falling) and `src_sel` = 0, a 1-to-0 pin change captures with the same latency as R2. A rising pin change does not capture.
- R4: With `edge_sel` = 3 (both), `src_sel` = 0 captures on both pin directions, and `src_sel` also captures on both software transitions (R6, R7).
- R5: With `edge_sel` = 0, nothing captures: no pin edge and no software rewrite.
- R6: With `edge_sel` bit 0 set (codes 1 or 3), changing `src_sel` from 2 to 3 before clock edge N raises `cap_strobe` in the cycle after edge N.
- R7: With `edge_sel` bit 1 set (codes 2 or 3), changing `src_sel` from 3 to 2 captures with the R6 timing. With `edge_sel` = 1, a 3-to-2 change does not capture.
- R8: Pin edges are ignored while `src_sel` is not 0. Changes between code 0 or 1 and any other code never capture.
- R9: Each capture loads `cap_value` with the `counter` input sampled at the clock edge that raises `cap_strobe`. At all other times `cap_value` holds its value.
- R10: A capture that occurs while an earlier value is still unread sets `ovf_flag`. A `read_ack` pulse marks the value as read, and a capture after that does not set the flag. The flag stays set until an `ovf_clr` pulse; if a set and a clear fall in the same cycle, the set wins.
- R11: Each trigger event gives a strobe exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | External capture input, asynchronous |
| edge_sel | input | 2 | 0 off, 1 rising, 2 falling, 3 both |
| src_sel | input | 2 | 0 pin, 1 none, 2 software low, 3 software high |
| counter | input | CNT_W | Free-running counter value |
| read_ack | input | 1 | Pulse: software has read `cap_value` |
| ovf_clr | input | 1 | Pulse: clear the overrun flag |
| cap_strobe | output | 1 | One-cycle capture pulse |
| cap_value | output | CNT_W | Captured counter value |
| ovf_flag | output | 1 | Sticky overrun flag |

## Verification
The bench checks the exact pin latency on both directions and against each edge-select code. A design with one synchroniser stage too few or too many would strobe a cycle early or late. It rewrites the source field in both directions under rising-only and falling-only selection, which catches a design that swaps the direction sense or ignores the setting. It also rewrites the field from code 0 straight to 3 and toggles the pin while software source is chosen; a decoder that looks only at the new code would then capture when it should not. The overrun tests put a read acknowledge between two captures and leave it out, and they check that the flag stays set until it is cleared. These catch a flag that is set by every capture, or one that clears itself.

// File: rtl/capture_edge_sel.sv
module capture_edge_sel #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       src_sel,
  input  logic [CNT_W-1:0] counter,
  input  logic             read_ack,
  input  logic             ovf_clr,
  output logic             cap_strobe,
  output logic [CNT_W-1:0] cap_value,
  output logic             ovf_flag
);

  localparam logic [1:0] SRC_PIN   = 2'd0;
  localparam logic [1:0] SRC_SW_LO = 2'd2;
  localparam logic [1:0] SRC_SW_HI = 2'd3;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_prev;
  logic [1:0]             src_q;
  logic                   unread;

  wire pin_now  = sync_q[SYNC_STAGES-1];
  wire use_pin  = (src_sel == SRC_PIN);
  wire pin_rise = use_pin &  pin_now & ~pin_prev;
  wire pin_fall = use_pin & ~pin_now &  pin_prev;
  wire sw_rise  = (src_q == SRC_SW_LO) && (src_sel == SRC_SW_HI);
  wire sw_fall  = (src_q == SRC_SW_HI) && (src_sel == SRC_SW_LO);

  // edge_sel bit 0 enables rising, bit 1 enables falling
  wire trig = (edge_sel[0] & (pin_rise | sw_rise)) |
              (edge_sel[1] & (pin_fall | sw_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      pin_prev <= 1'b0;
      src_q    <= SRC_PIN;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], cap_pin};
      pin_prev <= pin_now;
      src_q    <= src_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_strobe <= 1'b0;
      cap_value  <= '0;
      unread     <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      cap_strobe <= trig;
      if (trig) cap_value <= counter;
      unread   <= trig | (unread & ~read_ack);
      ovf_flag <= (trig & unread & ~read_ack) | (ovf_flag & ~ovf_clr);
    end
  end

  p_value_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |-> $stable(cap_value));

  p_value_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> cap_value == $past(counter));

  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_sel == 2'd0 |=> !cap_strobe);

  p_sw_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == 2'd2 && src_sel == 2'd3 && edge_sel[0]) |=> cap_strobe);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> cap_strobe);

endmodule

// File: tb/capture_edge_sel_tb.sv
module capture_edge_sel_tb;
  localparam int W = 16;

  logic clk = 0, rst_n = 0, cap_pin = 0, read_ack = 0, ovf_clr = 0;
  logic [1:0] edge_sel = 0, src_sel = 0;
  logic [W-1:0] counter = 0;
  logic cap_strobe, ovf_flag;
  logic [W-1:0] cap_value;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  capture_edge_sel #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .edge_sel(edge_sel),
    .src_sel(src_sel), .counter(counter), .read_ack(read_ack),
    .ovf_clr(ovf_clr), .cap_strobe(cap_strobe), .cap_value(cap_value),
    .ovf_flag(ovf_flag));

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tidy();
    read_ack = 1; ovf_clr = 1; step(); read_ack = 0; ovf_clr = 0;
  endtask

  // Strobe rises exactly lat steps after the stimulus, holds for one cycle
  task automatic expect_pulse(string tag, int lat, logic [W-1:0] val);
    for (int i = 1; i < lat; i++) begin step(); chk({tag, " early"}, cap_strobe, 0); end
    step();
    chk({tag, " strobe"}, cap_strobe, 1);
    chk({tag, " value"}, cap_value, val);
    step();
    chk({tag, " width R11"}, cap_strobe, 0);
  endtask

  task automatic expect_none(string tag, int n);
    logic seen = 0;
    for (int i = 0; i < n; i++) begin step(); seen |= cap_strobe; end
    chk(tag, seen, 0);
  endtask

  task automatic t_reset();
    chk("R1 strobe", cap_strobe, 0);
    chk("R1 value", cap_value, 0);
    chk("R1 ovf", ovf_flag, 0);
  endtask

  task automatic t_pin_rise();
    tidy(); edge_sel = 1; src_sel = 0; counter = 16'h1111; step();
    cap_pin = 1; expect_pulse("R2 rise", 3, 16'h1111);
    counter = 16'h2222; cap_pin = 0; expect_none("R2 fall ignored", 5);
    chk("R9 hold", cap_value, 16'h1111);
  endtask

  task automatic t_pin_fall();
    tidy(); edge_sel = 2; src_sel = 0; cap_pin = 0; counter = 16'h3333; step(4);
    cap_pin = 1; expect_none("R3 rise ignored", 5);
    cap_pin = 0; expect_pulse("R3 fall", 3, 16'h3333);
  endtask

  task automatic t_pin_both();
    tidy(); edge_sel = 3; src_sel = 0; cap_pin = 0; step(4);
    counter = 16'h4444; cap_pin = 1; expect_pulse("R4 pin rise", 3, 16'h4444);
    counter = 16'h5555; cap_pin = 0; expect_pulse("R4 pin fall", 3, 16'h5555);
  endtask

  task automatic t_disabled();
    tidy(); edge_sel = 0; src_sel = 0; cap_pin = 0; step(4);
    cap_pin = 1; expect_none("R5 pin rise", 5);
    cap_pin = 0; expect_none("R5 pin fall", 5);
    src_sel = 2; step(); src_sel = 3; expect_none("R5 sw 2->3", 2);
    src_sel = 2; expect_none("R5 sw 3->2", 2);
  endtask

  task automatic t_sw_rise();
    tidy(); edge_sel = 1; src_sel = 2; step();
    counter = 16'h6666; src_sel = 3; expect_pulse("R6 sw 2->3", 1, 16'h6666);
    src_sel = 2; expect_none("R7 3->2 under rise", 3);
  endtask

  task automatic t_sw_fall();
    tidy(); edge_sel = 2; src_sel = 2; step();
    src_sel = 3; expect_none("R7 2->3 under fall", 3);
    counter = 16'h7777; src_sel = 2; expect_pulse("R7 sw 3->2", 1, 16'h7777);
  endtask

  task automatic t_sw_both();
    tidy(); edge_sel = 3; src_sel = 2; step();
    counter = 16'h8888; src_sel = 3; expect_pulse("R4 sw up", 1, 16'h8888);
    counter = 16'h9999; src_sel = 2; expect_pulse("R4 sw down", 1, 16'h9999);
  endtask

  task automatic t_ignore();
    tidy(); edge_sel = 3; src_sel = 0; cap_pin = 0; step(4);
    src_sel = 3; expect_none("R8 0->3", 3);
    src_sel = 1; expect_none("R8 3->1", 3);
    src_sel = 2; step(); cap_pin = 1; expect_none("R8 pin while sw", 6);
    cap_pin = 0; expect_none("R8 pin fall while sw", 6);
    src_sel = 0; expect_none("R8 2->0", 3);
    chk("R8 value untouched", cap_value, 16'h9999);
  endtask

  task automatic t_overrun();
    tidy(); edge_sel = 3; src_sel = 2; step();
    counter = 16'hA001; src_sel = 3; step();
    read_ack = 1; step(); read_ack = 0;
    src_sel = 2; step();
    chk("R10 no ovf after read", ovf_flag, 0);
    src_sel = 3; step();
    chk("R10 ovf on unread", ovf_flag, 1);
    step(5);
    chk("R10 ovf sticky", ovf_flag, 1);
    ovf_clr = 1; step(); ovf_clr = 0;
    chk("R10 ovf cleared", ovf_flag, 0);
    src_sel = 2; ovf_clr = 1; step(); ovf_clr = 0;
    chk("R10 set beats clear", ovf_flag, 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1; step(2);
    src_sel = 3; step();
    chk("R1 first write no capture", cap_strobe, 0);
    src_sel = 0; step();
    t_pin_rise();
    t_pin_fall();
    t_pin_both();
    t_disabled();
    t_sw_rise();
    t_sw_fall();
    t_sw_both();
    t_ignore();
    t_overrun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule